// File: doc/BRIEF.md
# Display Line Dirty Tracker

This block keeps one dirty bit for each display line so that a display compressor knows which lines must be compressed again. Each pixel write to the frame buffer reports the line it touched, and the tracker marks that line as dirty. When the compressor finishes refreshing a line, it pulses a completion strobe, and the tracker clears that line's bit. The compressor reads the state of any line through a combinational query port.

The tracker also labels every frame as either an update frame or a static frame. Dirty lines are refreshed only in an update frame. With insert mode on, the label alternates at each start-of-frame strobe, so exactly one static frame sits between two update frames. With frame-wide marking on, any pixel write marks every line dirty. This mode is meant for linear buffers whose line pitch does not map cleanly onto the Y address.

Top module: `dirty_line_tracker`

## Requirements
- R1: After reset every line reads dirty (`query_dirty`=1 for every line) and `update_frame`=1.
- R2: With `frame_dirty_mode`=0, a write sets only the bit of line `wr_line`, visible from the clock edge that takes the write. Other lines keep their state.
- R3: With `frame_dirty_mode`=1, any write sets the bits of all lines, visible from the next clock edge.
- R4: When `refresh_valid`=1 and `update_frame`=1, the bit of `refresh_line` clears at the clock edge. Other lines keep their state.
- R5: When `update_frame`=0 (static frame), `refresh_valid` has no effect on any dirty bit.
- R6: When a write and an update-frame refresh name the same line in the same cycle, that line stays dirty.
- R7: With `insert_mode`=1, each `sof` pulse inverts `update_frame` at the clock edge, so update and static frames alternate one for one.
- R8: With `insert_mode`=0, each `sof` pulse leaves `update_frame`=1.
- R9: `update_frame` changes only on a cycle with `sof`=1. Changing `insert_mode` in the middle of a frame does not change the current frame's label.
- R10: `query_dirty` combinationally shows the bit of line `query_line`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Pixel write notification |
| wr_line | input | YW | Line index of the pixel write |
| frame_dirty_mode | input | 1 | 1: any write marks all lines dirty |
| insert_mode | input | 1 | 1: alternate update and static frames |
| sof | input | 1 | Start-of-frame strobe |
| refresh_valid | input | 1 | Line refresh completed |
| refresh_line | input | YW | Line index of the completed refresh |
| query_line | input | YW | Line index to query |
| query_dirty | output | 1 | Dirty bit of `query_line` |
| update_frame | output | 1 | 1: update frame, 0: static frame |

## Verification
The bench first clears every line, then writes single lines and checks the lines next to them, so a write that spills onto a neighbour or lands on the wrong index is caught. It repeats refreshes across a static and an update frame, which separates a refresh that is ignored from one that takes effect. A write and a refresh to the same line in one cycle show which of the two takes priority. The bench then steps start-of-frame strobes with insert mode on and off, and changes insert mode between strobes, which separates toggling at the frame edge from toggling at any time.

// File: rtl/dirty_line_tracker.sv
module dirty_line_tracker #(
  parameter int LINES = 1024,
  localparam int YW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [YW-1:0] wr_line,
  input  logic          frame_dirty_mode,
  input  logic          insert_mode,
  input  logic          sof,
  input  logic          refresh_valid,
  input  logic [YW-1:0] refresh_line,
  input  logic [YW-1:0] query_line,
  output logic          query_dirty,
  output logic          update_frame
);

  logic [LINES-1:0] dirty;
  logic [LINES-1:0] set_mask;
  logic [LINES-1:0] clr_mask;

  assign set_mask = wr_valid ? (LINES'(1) << wr_line) : '0;
  assign clr_mask = (refresh_valid && update_frame) ? (LINES'(1) << refresh_line) : '0;
  assign query_dirty = dirty[query_line];

  always_ff @(posedge clk) begin
    if (!rst_n)
      dirty <= '1;
    else if (wr_valid && frame_dirty_mode)
      dirty <= '1;
    else
      dirty <= (dirty & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      update_frame <= 1'b1;
    else if (sof)
      update_frame <= insert_mode ? ~update_frame : 1'b1;
  end

  p_line_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !frame_dirty_mode |=> dirty[$past(wr_line)]);

  p_frame_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && frame_dirty_mode |=> &dirty);

  p_static_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !update_frame && !wr_valid |=> $stable(dirty));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && refresh_valid && (wr_line == refresh_line) |=> dirty[$past(wr_line)]);

  p_insert_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof && insert_mode |=> update_frame != $past(update_frame));

  p_plain_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof && !insert_mode |=> update_frame);

  p_flag_at_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(update_frame));

endmodule

// File: tb/dirty_line_tracker_test.sv
module dirty_line_tracker_test;
  localparam int LINES = 1024;
  localparam int YW = $clog2(LINES);

  logic clk = 0;
  logic rst_n = 0;
  logic wr_valid = 0, frame_dirty_mode = 0, insert_mode = 0, sof = 0, refresh_valid = 0;
  logic [YW-1:0] wr_line = '0, refresh_line = '0, query_line = '0;
  logic query_dirty, update_frame;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dirty_line_tracker #(.LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_line(wr_line),
    .frame_dirty_mode(frame_dirty_mode), .insert_mode(insert_mode), .sof(sof),
    .refresh_valid(refresh_valid), .refresh_line(refresh_line),
    .query_line(query_line), .query_dirty(query_dirty), .update_frame(update_frame)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic line_is(input int ln, input logic exp, input string req);
    query_line = YW'(ln);
    #1;
    check(query_dirty, exp, req);
  endtask

  task automatic write_line(input int ln);
    wr_valid = 1; wr_line = YW'(ln);
    step();
    wr_valid = 0;
  endtask

  task automatic refresh(input int ln);
    refresh_valid = 1; refresh_line = YW'(ln);
    step();
    refresh_valid = 0;
  endtask

  task automatic frame_start();
    sof = 1;
    step();
    sof = 0;
  endtask

  task automatic t_reset();
    line_is(0, 1, "R1 line 0");
    line_is(513, 1, "R1 line 513");
    line_is(LINES-1, 1, "R1 last line");
    check(update_frame, 1, "R1 update_frame");
  endtask

  task automatic t_clear_all();
    for (int i = 0; i < LINES; i++) refresh(i);
    line_is(0, 0, "R4 line 0 cleared");
    line_is(5, 0, "R4 line 5 cleared");
    line_is(LINES-1, 0, "R4 last line cleared");
  endtask

  task automatic t_line_write();
    write_line(7);
    line_is(7, 1, "R2 line 7 set");
    line_is(6, 0, "R2 line 6 untouched");
    line_is(8, 0, "R2 line 8 untouched");
    write_line(LINES-1);
    line_is(LINES-1, 1, "R2 last line set");
    line_is(0, 0, "R2 line 0 untouched");
    refresh(7);
    line_is(7, 0, "R4 line 7 cleared");
    line_is(LINES-1, 1, "R4 other line kept");
    refresh(LINES-1);
  endtask

  task automatic t_query_comb();
    write_line(20);
    query_line = YW'(20); #1;
    check(query_dirty, 1, "R10 query 20");
    query_line = YW'(21); #1;
    check(query_dirty, 0, "R10 query 21 without clock");
    refresh(20);
  endtask

  task automatic t_insert_frames();
    insert_mode = 1;
    step();
    check(update_frame, 1, "R9 no mid-frame change");
    frame_start();
    check(update_frame, 0, "R7 static after sof");
    write_line(9);
    refresh(9);
    line_is(9, 1, "R5 refresh ignored in static frame");
    step(); step();
    check(update_frame, 0, "R9 flag held without sof");
    frame_start();
    check(update_frame, 1, "R7 update after sof");
    refresh(9);
    line_is(9, 0, "R4 refresh in update frame");
    frame_start();
    check(update_frame, 0, "R7 static again");
    insert_mode = 0;
    step();
    check(update_frame, 0, "R9 disable mid-frame no change");
  endtask

  task automatic t_no_insert();
    frame_start();
    check(update_frame, 1, "R8 update after sof");
    frame_start();
    check(update_frame, 1, "R8 still update");
  endtask

  task automatic t_collision();
    wr_valid = 1; wr_line = YW'(10);
    refresh_valid = 1; refresh_line = YW'(10);
    step();
    wr_valid = 0; refresh_valid = 0;
    line_is(10, 1, "R6 write wins");
    refresh(10);
    line_is(10, 0, "R6 later refresh clears");
  endtask

  task automatic t_frame_dirty();
    frame_dirty_mode = 1;
    write_line(3);
    frame_dirty_mode = 0;
    line_is(0, 1, "R3 line 0");
    line_is(3, 1, "R3 line 3");
    line_is(600, 1, "R3 line 600");
    line_is(LINES-1, 1, "R3 last line");
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    #1;
    t_reset();
    t_clear_all();
    t_line_write();
    t_query_comb();
    t_insert_frames();
    t_no_insert();
    t_collision();
    t_frame_dirty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule